// File: doc/BRIEF.md
# Write-Strobe Qualifier with Power-Up Holdoff

This block sits between the external write strobes of a non-volatile memory and its internal program engine. It watches the chip-select, output-enable and write strobes together with two digital health flags: one saying the core supply is above its sense level, and one saying the programming voltage is usable. From these it produces a single-clock program trigger. Everything runs on one fast clock, and all five inputs are first passed through a two-flop synchronizer.

A write pulse is the interval during which chip-select and write are both low after synchronization, so either strobe may frame it. When the pulse ends, the block issues the trigger only if three things hold. The pulse lasted at least a set number of clock cycles. Output-enable stayed high for the whole pulse. The power-up holdoff had expired and the programming voltage was good for the whole pulse. The holdoff counts a set number of cycles after the supply flag goes high. It starts again from zero whenever the supply flag drops.

Top module: `wr_guard`

## Requirements
- R1: After reset the trigger output is low, and the holdoff is not complete even if the supply flag is already high.
- R2: While the synchronized supply flag is low, no write pulse produces a trigger.
- R3: A write pulse is rejected until HOLDOFF_CYC clock cycles have passed with the supply flag high. A write pulse made after that produces a trigger.
- R4: If the supply flag drops during the holdoff count, the count starts again from zero once the flag returns high.
- R5: A write pulse during which output-enable is low, on any cycle, produces no trigger.
- R6: A write pulse during which the programming-voltage flag is low, on any cycle, produces no trigger.
- R7: A write pulse that lasts fewer than MIN_W clock cycles produces no trigger. A pulse of exactly MIN_W cycles produces one.
- R8: Each qualified pulse produces exactly one trigger, one clock cycle wide, however long the pulse lasts. The trigger goes high on the third rising edge after the terminating strobe returns high: two edges for synchronization and one registered decision.
- R9: A write pulse is the time during which chip-select and write are both low (active-low). Holding write low while pulsing chip-select makes a valid pulse. Pulsing chip-select while write stays high produces no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n_i | input | 1 | Chip-select strobe, active low, asynchronous |
| oe_n_i | input | 1 | Output-enable strobe, active low, asynchronous |
| we_n_i | input | 1 | Write strobe, active low, asynchronous |
| vdd_ok_i | input | 1 | High when the core supply is above its sense level |
| vpp_ok_i | input | 1 | High when the programming voltage is usable |
| prog_trig_o | output | 1 | One-cycle qualified program trigger, registered |

## Verification
The assertions assume that each input is a level that holds for whole clock cycles once it has been synchronized. They also assume reset is held long enough to fill the synchronizer with inactive values. The bench changes every input only on the falling clock edge and keeps each level for an integer number of cycles. A pulse of N low cycles at the pins therefore becomes exactly N active cycles inside the block, which makes the width limits exact. The health flags change only while no strobe is active, except in the one case that deliberately makes a flag go bad in the middle of a pulse.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic vdd_ok;
    logic vpp_ok;
  } wg_pins_t;

  // Idle strobes, health flags reported bad
  localparam wg_pins_t WG_SAFE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                   vdd_ok: 1'b0, vpp_ok: 1'b0};
  localparam int WG_SYNC_STAGES = 2;
endpackage

// File: rtl/wg_sync.sv
module wg_sync #(
  parameter int            W       = 5,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wg_holdoff.sv
module wg_holdoff #(
  parameter int HOLDOFF_CYC = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic vdd_ok,
  output logic ready
);
  localparam int CNT_W = (HOLDOFF_CYC > 2) ? $clog2(HOLDOFF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLDOFF_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !vdd_ok) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == LAST) ready <= 1'b1;
      else             cnt   <= cnt + CNT_W'(1);
    end
  end

  // R2
  ready_vdd_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(vdd_ok));

  // R3
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/wg_qual.sv
module wg_qual #(
  parameter int MIN_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic inhibit,
  output logic trig
);
  localparam int WC_W = $clog2(MIN_W + 1);
  localparam logic [WC_W-1:0] WMAX = WC_W'(MIN_W);

  logic            in_pulse;
  logic            bad;
  logic [WC_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pulse <= 1'b0;
      bad      <= 1'b0;
      wcnt     <= '0;
      trig     <= 1'b0;
    end else begin
      trig <= 1'b0;
      if (active) begin
        in_pulse <= 1'b1;
        if (wcnt != WMAX) wcnt <= wcnt + WC_W'(1);
        if (inhibit)      bad  <= 1'b1;
      end else begin
        if (in_pulse) trig <= (wcnt == WMAX) && !bad;
        in_pulse <= 1'b0;
        wcnt     <= '0;
        bad      <= 1'b0;
      end
    end
  end

  // R8
  trig_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);

  // R8
  trig_idle_chk: assert property (@(posedge clk) disable iff (rst)
    active |=> !trig);

  // R7
  trig_width_chk: assert property (@(posedge clk) disable iff (rst)
    trig |-> ($past(wcnt) == WMAX));
endmodule

// File: rtl/wr_guard.sv
module wr_guard
  import wg_pkg::*;
#(
  parameter int HOLDOFF_CYC = 2500000,
  parameter int MIN_W       = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_n_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  input  logic vdd_ok_i,
  input  logic vpp_ok_i,
  output logic prog_trig_o
);
  wg_pins_t raw, syn;
  logic     ready, active, inhibit;

  assign raw = '{ce_n: ce_n_i, oe_n: oe_n_i, we_n: we_n_i,
                 vdd_ok: vdd_ok_i, vpp_ok: vpp_ok_i};

  wg_sync #(.W($bits(wg_pins_t)), .STAGES(WG_SYNC_STAGES), .RST_VAL(WG_SAFE)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  wg_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_hold (
    .clk(clk), .rst(rst), .vdd_ok(syn.vdd_ok), .ready(ready)
  );

  assign active  = !syn.ce_n && !syn.we_n;
  assign inhibit = !syn.oe_n || !ready || !syn.vpp_ok;

  wg_qual #(.MIN_W(MIN_W)) u_qual (
    .clk(clk), .rst(rst), .active(active), .inhibit(inhibit), .trig(prog_trig_o)
  );

  // R2
  trig_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    prog_trig_o |-> $past(syn.vdd_ok, 2));
endmodule

// File: tb/wr_guard_bench.sv
module wr_guard_bench;
  localparam int HOLD = 50;
  localparam int MINW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vdd = 1'b0, vpp = 1'b1;
  logic trig;
  int   vec = 0, bad = 0, tcnt = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  wr_guard #(.HOLDOFF_CYC(HOLD), .MIN_W(MINW)) u_wr_guard (
    .clk(clk), .rst(rst), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .vdd_ok_i(vdd), .vpp_ok_i(vpp), .prog_trig_o(trig)
  );

  always @(negedge clk) if (trig) tcnt++;

  task automatic chk(string req, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // mode 0: both strobes low; 1: we held low, ce pulsed; 2: ce pulsed, we high
  task automatic pulse(int len, int mode, output int ntrig);
    @(negedge clk);
    tcnt = 0;
    if (mode != 2) we_n = 1'b0;
    if (mode == 1) idle(2);
    ce_n = 1'b0;
    idle(len);
    ce_n = 1'b1;
    if (mode == 1) idle(2);
    we_n = 1'b1;
    idle(8);
    ntrig = tcnt;
  endtask

  task automatic t_reset();
    chk("R1 trig after reset", int'(trig), 0);
  endtask

  task automatic t_supply_low();
    int n;
    pulse(8, 0, n);
    chk("R2 supply low", n, 0);
  endtask

  task automatic t_holdoff();
    int n;
    vdd = 1'b1;
    idle(5);
    pulse(8, 0, n);
    chk("R1 holdoff pending after reset", n, 0);
    idle(60);
    pulse(8, 0, n);
    chk("R3 after holdoff", n, 1);
  endtask

  task automatic t_restart();
    int n;
    vdd = 1'b0; idle(5);
    vdd = 1'b1; idle(30);
    vdd = 1'b0; idle(3);
    vdd = 1'b1; idle(30);
    pulse(8, 0, n);
    chk("R4 restarted count", n, 0);
    idle(40);
    pulse(8, 0, n);
    chk("R4 after full recount", n, 1);
  endtask

  task automatic t_oe();
    int n;
    oe_n = 1'b0;
    pulse(8, 0, n);
    oe_n = 1'b1;
    chk("R5 oe low whole pulse", n, 0);
    @(negedge clk);
    tcnt = 0;
    ce_n = 1'b0; we_n = 1'b0;
    idle(3); oe_n = 1'b0; idle(1); oe_n = 1'b1; idle(4);
    ce_n = 1'b1; we_n = 1'b1;
    idle(8);
    chk("R5 oe low one cycle", tcnt, 0);
  endtask

  task automatic t_vpp();
    int n;
    vpp = 1'b0;
    pulse(8, 0, n);
    vpp = 1'b1;
    chk("R6 vpp low", n, 0);
    pulse(8, 0, n);
    chk("R6 vpp restored", n, 1);
  endtask

  task automatic t_width();
    int n;
    pulse(MINW - 1, 0, n); chk("R7 width MIN_W-1", n, 0);
    pulse(MINW, 0, n);     chk("R7 width MIN_W", n, 1);
    pulse(1, 0, n);        chk("R7 width 1", n, 0);
  endtask

  task automatic t_timing();
    int n;
    @(negedge clk);
    tcnt = 0;
    ce_n = 1'b0; we_n = 1'b0;
    idle(8);
    we_n = 1'b1;
    @(negedge clk); chk("R8 edge 1", int'(trig), 0);
    @(negedge clk); chk("R8 edge 2", int'(trig), 0);
    @(negedge clk); chk("R8 edge 3", int'(trig), 1);
    @(negedge clk); chk("R8 edge 4", int'(trig), 0);
    ce_n = 1'b1;
    idle(6);
    chk("R8 single trigger", tcnt, 1);
    pulse(30, 0, n);
    chk("R8 long pulse once", n, 1);
  endtask

  task automatic t_ce_frame();
    int n;
    pulse(6, 1, n); chk("R9 ce framed", n, 1);
    pulse(6, 2, n); chk("R9 ce with we high", n, 0);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_supply_low();
    t_holdoff();
    t_restart();
    t_oe();
    t_vpp();
    t_width();
    t_timing();
    t_ce_frame();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      vec++;
      bad++;
      $display("FAIL watchdog: got 0 expected 1 (run ended)");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule